// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block watches a switching regulator through single-bit comparator results that arrive synchronous to the system clock. It filters each fault source for a set persistence time and applies that source's soft-start masking rule. Any qualified fault sets one sticky fault latch. Persistence windows are cycle-count parameters derived from the system clock frequency. A restart of a window happens whenever its condition drops for even one cycle.

Once the latch is set, the block stops passing the modulator's low-side request to the gate. It then discharges the output in a hysteretic pattern instead. The gate is held on until the output drops under its low threshold, then held off until the output climbs over its high threshold, and the cycle repeats. A discharge load is switched in whenever the latch is set or the regulator is disabled. A power-good output summarises soft-start completion, the latch, the feedback window and the termination-rail status.

Top module: `reg_fault_supervisor`

## Requirements
- R1: With `en` high and `ss_low` low, `uv_flag` high for UV_CYC consecutive clock cycles (400 at 200 MHz, 2 us) sets `fault` at the next edge. A single low cycle restarts the count.
- R2: While `ss_low` is high, `uv_flag` never contributes to setting `fault`, however long it is held.
- R3: `ov_flag` held high across OV_TICKS (16) consecutive `sw_tick` pulses sets `fault` at the edge after the sixteenth pulse. Any low cycle of `ov_flag` restarts the count. The rule applies during soft-start too.
- R4: While `ss_done` is low, `vout_gt_1v` and `fb_near_gnd` both high for FBS_CYC consecutive cycles (2801 at 200 MHz, more than 14 us) set `fault`. While `ss_done` is high this condition is ignored.
- R5: A one-cycle `hs_fault` or `oc_fault` with `en` high sets `fault` at the next edge, even during soft-start. `fault` then stays high for as long as `en` stays high.
- R6: While `fault` is high, `ldrv` is driven high when the latch sets and stays high until `vout_lt_0v5` is seen. It then stays low until `vout_gt_0v8` is seen, and the pattern repeats. Each change takes effect one edge after the threshold flag is sampled.
- R7: While `fault` is low, `ldrv` equals `pwm_ldrv` in the same cycle.
- R8: Reset clears `fault`. `en` low clears `fault` at the next edge and keeps every source from setting it, so an enable toggle restarts the regulator.
- R9: `dis_load` is high exactly when `fault` is high or `en` is low.
- R10: `pgood` is high exactly when `ss_done`, `fb_in_win` and `vtt_ok` are high and `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| en | input | 1 | Regulator enable |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| uv_flag | input | 1 | Feedback below under-voltage threshold |
| ov_flag | input | 1 | Feedback above over-voltage threshold |
| fb_near_gnd | input | 1 | Feedback below 100 mV |
| vout_gt_1v | input | 1 | Output above 1 V |
| vout_lt_0v5 | input | 1 | Output below 0.5 V |
| vout_gt_0v8 | input | 1 | Output above 0.8 V |
| hs_fault | input | 1 | High-side switch fault detected |
| oc_fault | input | 1 | Fault request from the over-current logic |
| ss_low | input | 1 | Soft-start below its 1.3 V level |
| ss_done | input | 1 | Soft-start above its 3.5 V level |
| fb_in_win | input | 1 | Feedback inside 90-110 % window |
| vtt_ok | input | 1 | Termination rail in regulation |
| pwm_ldrv | input | 1 | Low-side gate request from the modulator |
| ldrv | output | 1 | Low-side gate drive |
| dis_load | output | 1 | Discharge load enable |
| pgood | output | 1 | Power good |
| fault | output | 1 | Fault latch state |

## Verification
The delicate coincidence is the cycle in which the latch sets while a discharge threshold flag or a modulator edge is also changing. The gate output must switch from the modulator request to the discharge pattern at exactly that edge. A second coincidence is an enable toggle that lands while a persistence counter is partway through. The bench drives both of these, toggling `pwm_ldrv` and holding `vout_lt_0v5` at the moment a fault trips. A behavioural reference model, advanced with the design on every clock, judges all four outputs each cycle.

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
  parameter int CLK_MHZ  = 200,
  parameter int UV_NS    = 2000,
  parameter int FBS_NS   = 14000,
  parameter int OV_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sw_tick,
  input  logic uv_flag,
  input  logic ov_flag,
  input  logic fb_near_gnd,
  input  logic vout_gt_1v,
  input  logic vout_lt_0v5,
  input  logic vout_gt_0v8,
  input  logic hs_fault,
  input  logic oc_fault,
  input  logic ss_low,
  input  logic ss_done,
  input  logic fb_in_win,
  input  logic vtt_ok,
  input  logic pwm_ldrv,
  output logic ldrv,
  output logic dis_load,
  output logic pgood,
  output logic fault
);
  localparam int UV_CYC  = CLK_MHZ * UV_NS / 1000;
  localparam int FBS_CYC = CLK_MHZ * FBS_NS / 1000 + 1;
  localparam int UV_W    = $clog2(UV_CYC + 1);
  localparam int FBS_W   = $clog2(FBS_CYC + 1);
  localparam int OV_W    = $clog2(OV_TICKS + 1);

  logic [UV_W-1:0]  uv_cnt;
  logic [FBS_W-1:0] fbs_cnt;
  logic [OV_W-1:0]  ov_cnt;
  logic             pull;

  wire uv_cond  = en & uv_flag & ~ss_low;
  wire fbs_cond = en & vout_gt_1v & fb_near_gnd & ~ss_done;
  wire ov_cond  = en & ov_flag;

  wire uv_trip  = uv_cond  && (uv_cnt  == UV_W'(UV_CYC - 1));
  wire fbs_trip = fbs_cond && (fbs_cnt == FBS_W'(FBS_CYC - 1));
  wire ov_trip  = ov_cond && sw_tick && (ov_cnt == OV_W'(OV_TICKS - 1));
  wire set_req  = uv_trip | fbs_trip | ov_trip | (en & (hs_fault | oc_fault));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_cnt  <= '0;
      fbs_cnt <= '0;
      ov_cnt  <= '0;
    end else begin
      if (!uv_cond) uv_cnt <= '0;
      else if (uv_cnt != UV_W'(UV_CYC - 1)) uv_cnt <= uv_cnt + 1'b1;
      if (!fbs_cond) fbs_cnt <= '0;
      else if (fbs_cnt != FBS_W'(FBS_CYC - 1)) fbs_cnt <= fbs_cnt + 1'b1;
      if (!ov_cond) ov_cnt <= '0;
      else if (sw_tick && ov_cnt != OV_W'(OV_TICKS - 1)) ov_cnt <= ov_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault <= 1'b0;
      pull  <= 1'b1;
    end else begin
      if (!en) fault <= 1'b0;
      else if (set_req) fault <= 1'b1;
      if (!fault) pull <= 1'b1;
      else if (pull && vout_lt_0v5) pull <= 1'b0;
      else if (!pull && vout_gt_0v8) pull <= 1'b1;
    end
  end

  assign ldrv     = fault ? pull : pwm_ldrv;
  assign dis_load = fault | ~en;
  assign pgood    = ss_done & fb_in_win & vtt_ok & ~fault;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en) |=> fault);
  a_r8_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fault);
  a_r6_hold_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en && ldrv && !vout_lt_0v5) |=> ldrv);
  a_r6_hold_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en && !ldrv && !vout_gt_0v8) |=> !ldrv);
  a_r2_uv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && en && ss_low && !ov_flag && !hs_fault && !oc_fault && !vout_gt_1v) |=> !fault);
endmodule

// File: tb/reg_fault_supervisor_tb.sv
`timescale 1ns/1ps
module reg_fault_supervisor_tb;
  localparam int UV_CYC  = 400;
  localparam int FBS_CYC = 2801;
  localparam int OV_N    = 16;

  logic clk = 0, rst_n = 0, en = 0, sw_tick = 0;
  logic uv_flag = 0, ov_flag = 0, fb_near_gnd = 0, vout_gt_1v = 0;
  logic vout_lt_0v5 = 0, vout_gt_0v8 = 0, hs_fault = 0, oc_fault = 0;
  logic ss_low = 0, ss_done = 0, fb_in_win = 0, vtt_ok = 0, pwm_ldrv = 0;
  logic ldrv, dis_load, pgood, fault;

  int vectors = 0, miscompares = 0;
  string tag = "R8";
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_tick(sw_tick),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .fb_near_gnd(fb_near_gnd),
    .vout_gt_1v(vout_gt_1v), .vout_lt_0v5(vout_lt_0v5), .vout_gt_0v8(vout_gt_0v8),
    .hs_fault(hs_fault), .oc_fault(oc_fault), .ss_low(ss_low), .ss_done(ss_done),
    .fb_in_win(fb_in_win), .vtt_ok(vtt_ok), .pwm_ldrv(pwm_ldrv),
    .ldrv(ldrv), .dis_load(dis_load), .pgood(pgood), .fault(fault));

  // behavioural reference
  int  uv_run = 0, fb_run = 0, ov_run = 0;
  bit  m_fault = 0, m_pull = 1;
  always @(posedge clk) begin
    bit set;
    if (!rst_n) begin
      uv_run = 0; fb_run = 0; ov_run = 0; m_fault = 0; m_pull = 1;
    end else begin
      set = 0;
      uv_run = (en && uv_flag && !ss_low) ? uv_run + 1 : 0;
      if (uv_run >= UV_CYC) set = 1;
      fb_run = (en && vout_gt_1v && fb_near_gnd && !ss_done) ? fb_run + 1 : 0;
      if (fb_run >= FBS_CYC) set = 1;
      if (!(en && ov_flag)) ov_run = 0;
      else if (sw_tick) begin
        ov_run = ov_run + 1;
        if (ov_run >= OV_N) set = 1;
      end
      if (en && (hs_fault || oc_fault)) set = 1;
      if (!m_fault) m_pull = 1;
      else if (m_pull && vout_lt_0v5) m_pull = 0;
      else if (!m_pull && vout_gt_0v8) m_pull = 1;
      m_fault = !en ? 0 : (m_fault | set);
    end
  end

  task automatic chk(string t, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    chk(tag, fault, m_fault, "fault");
    chk((m_fault ? "R6" : "R7"), ldrv, m_fault ? m_pull : pwm_ldrv, "ldrv");
    chk("R9", dis_load, m_fault | ~en, "dis_load");
    chk("R10", pgood, ss_done & fb_in_win & vtt_ok & ~m_fault, "pgood");
  end

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      sw_tick = (n % 8 == 7);
      n++;
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic toggle_en();
    en = 0; cyc(3); en = 1; cyc(2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    tag = "R8"; cyc(3); rst_n = 1; cyc(2);
    en = 1; ss_low = 1; cyc(3);
    // R2: long under-voltage masked by soft-start
    tag = "R2"; uv_flag = 1; cyc(600); uv_flag = 0; cyc(2);
    // R1: broken run restarts, then full run trips; modulator toggling at trip
    tag = "R1"; ss_low = 0;
    uv_flag = 1; cyc(300); uv_flag = 0; cyc(1); uv_flag = 1;
    vout_lt_0v5 = 1;
    for (int i = 0; i < 420; i++) begin pwm_ldrv = i[0]; cyc(1); end
    uv_flag = 0;
    // R6: hysteretic discharge
    tag = "R6"; vout_lt_0v5 = 0; cyc(3); vout_lt_0v5 = 1; cyc(4); vout_lt_0v5 = 0;
    cyc(5); vout_gt_0v8 = 1; cyc(3); vout_gt_0v8 = 0; cyc(4);
    vout_lt_0v5 = 1; vout_gt_0v8 = 1; cyc(6); vout_lt_0v5 = 0; vout_gt_0v8 = 0;
    // R8: enable toggle clears, counter mid-way is restarted by enable low
    tag = "R8"; toggle_en();
    uv_flag = 1; cyc(250); en = 0; cyc(2); en = 1; cyc(250); uv_flag = 0; cyc(3);
    // R7: passthrough
    tag = "R7";
    for (int i = 0; i < 20; i++) begin pwm_ldrv = (i % 3 == 0); cyc(1); end
    // R3: over-voltage ticks, interrupted then full
    tag = "R3"; ss_low = 1; ov_flag = 1; cyc(8*10); ov_flag = 0; cyc(1);
    ov_flag = 1; cyc(8*(OV_N+2)); ov_flag = 0; toggle_en();
    // R4: masked after soft-start, then tripping during soft-start
    tag = "R4"; ss_low = 0; ss_done = 1; fb_in_win = 1; vtt_ok = 1;
    vout_gt_1v = 1; fb_near_gnd = 1; cyc(FBS_CYC + 100);
    ss_done = 0; cyc(FBS_CYC - 10); fb_near_gnd = 0; cyc(1); fb_near_gnd = 1;
    cyc(FBS_CYC + 5); vout_gt_1v = 0; fb_near_gnd = 0; toggle_en();
    // R5: immediate sources during soft-start
    tag = "R5"; ss_low = 1; hs_fault = 1; cyc(1); hs_fault = 0; cyc(20);
    toggle_en(); oc_fault = 1; cyc(1); oc_fault = 0; cyc(10);
    en = 0; oc_fault = 1; cyc(3); oc_fault = 0; en = 1; cyc(3);
    // R10: power-good combinations
    tag = "R10"; ss_low = 0;
    for (int i = 0; i < 8; i++) begin
      ss_done = i[0]; fb_in_win = i[1]; vtt_ok = i[2]; cyc(2);
    end
    hs_fault = 1; cyc(1); hs_fault = 0; cyc(4);
    tag = "R9"; en = 0; cyc(3); en = 1; cyc(3);
    done = 1;
    finish_run();
  end
endmodule